// File: doc/BRIEF.md
# Overloaded Command Dispatch Router

This block executes the eight overloaded register-register command instructions (command index 0 to 7) on behalf of a core. Each command arrives with two source operands. The low field of the first operand names a logical unit, and the router uses it to pick one of several attached device ports. It passes the command index, the remaining upper bits of the first operand and the whole second operand to that device over a valid/ready request channel. It then waits for the device's single result on a valid/ready response channel and returns that result to the core as the destination value.

Unit number zero is reserved as the null unit and never reaches a device. A nonzero unit that no device claims is treated the same way. A build-time fallback mode decides what happens to such a command: it raises a one-cycle trap strobe that carries the offending unit number, it completes with a result of zero, or it completes with a result of all ones. Only one command is in flight at a time. The core-side ready signal drops from acceptance until the device's response handshake.

Top module: `cmd_dispatch_router`

## Requirements
- R1: After reset the router is idle: `req_ready` is 1, and `rsp_valid`, `trap_valid` and every `dev_req_valid` bit are 0.
- R2: The unit number is `req_src1[11:0]`. When it is nonzero and equals entry i of `DEV_UNITS` (entry i sits at bits [12*i+11:12*i]), only `dev_req_valid[i]` is raised. At most one request valid bit is ever high.
- R3: The device sees `dev_req_cmd` equal to the 3-bit command index, `dev_req_data` equal to `req_src1[XLEN-1:12]` and `dev_req_src2` equal to `req_src2`, all unchanged.
- R4: The selected device's `dev_rsp_data` slice is returned on `rsp_data`, with a single-cycle `rsp_valid` in the cycle after the device's response handshake.
- R5: Only one command is outstanding. `req_ready` is 0 from the cycle after acceptance until the device's response handshake completes.
- R6: A command to unit 0 is never sent to any device. In trap mode (`FALLBACK = FB_TRAP`) `trap_valid` is high for one cycle, in the cycle after acceptance, with `trap_unit` equal to the unit number, and `rsp_valid` stays 0 for that command.
- R7: In zero mode (`FB_ZERO`) a null-unit command completes with `rsp_valid` one cycle after acceptance and `rsp_data` equal to 0, and raises no trap.
- R8: In all-ones mode (`FB_ONES`) a null-unit command completes with `rsp_valid` one cycle after acceptance and `rsp_data` equal to all ones, and raises no trap.
- R9: A nonzero unit number that matches no entry of `DEV_UNITS` behaves exactly like unit 0 under the active fallback mode.
- R10: While a request valid bit is high and the device has not given ready, the valid bit and the command, data and second-operand outputs hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Core offers a command |
| req_ready | output | 1 | Router can accept a command |
| req_cmd | input | 3 | Command index 0..7 |
| req_src1 | input | XLEN | First operand: unit in [11:0], device data above |
| req_src2 | input | XLEN | Second operand |
| rsp_valid | output | 1 | Destination value is valid (one cycle) |
| rsp_data | output | XLEN | Destination value |
| trap_valid | output | 1 | Null or unknown unit trap strobe |
| trap_unit | output | 12 | Unit number that caused the trap |
| dev_req_valid | output | NUM_DEV | Per-device request valid |
| dev_req_ready | input | NUM_DEV | Per-device request ready |
| dev_req_cmd | output | 3 | Command index to the devices |
| dev_req_data | output | XLEN-12 | Upper bits of the first operand |
| dev_req_src2 | output | XLEN | Second operand to the devices |
| dev_rsp_valid | input | NUM_DEV | Per-device response valid |
| dev_rsp_ready | output | NUM_DEV | Per-device response ready |
| dev_rsp_data | input | NUM_DEV*XLEN | Per-device results, device i at bits [XLEN*i+XLEN-1:XLEN*i] |

## Verification
The assertions watch every cycle for properties that hold regardless of the traffic. At most one device request is active, a device request never carries unit zero, a stalled request holds its payload, and a trap never coincides with a write-back. The core is also blocked while a device owns the command. Whether the right device was chosen, whether the payload and result arrive unaltered, and what each fallback mode returns can only be shown by the bench's scenarios. The bench covers devices with different stall lengths, unit numbers at both ends of the 12-bit range, unmapped units, and separate instances built in the zero and all-ones modes.

// File: rtl/cdr_pkg.sv
// Shared definitions for the overloaded command dispatch router.
// Assumes the unit field is 12 bits and the command index is 3 bits.
package cdr_pkg;
    localparam int UNIT_W = 12;
    localparam int CMD_W  = 3;

    // Handling of a command whose unit number reaches no device
    typedef enum logic [1:0] {
        FB_TRAP = 2'd0,
        FB_ZERO = 2'd1,
        FB_ONES = 2'd2
    } fallback_e;

    // Controller sequencing states
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2
    } ctl_state_e;
endpackage

// File: rtl/cdr_unit_lookup.sv
// Unit lookup: compares a unit number with each device's configured unit.
// Reports a hit and the lowest matching device index. Unit 0 never hits,
// even if a map entry holds 0.
module cdr_unit_lookup #(
    parameter int NUM_DEV = 4,
    parameter int UNIT_W  = 12,
    parameter int IDX_W   = 2,
    parameter logic [NUM_DEV*UNIT_W-1:0] UNIT_MAP = '0
) (
    input  logic [UNIT_W-1:0] unit,
    output logic              hit,
    output logic [IDX_W-1:0]  idx
);
    logic [NUM_DEV-1:0] match;

    // One comparator for each device port
    for (genvar g = 0; g < NUM_DEV; g++) begin : g_cmp
        assign match[g] = (unit != '0) && (unit == UNIT_MAP[g*UNIT_W +: UNIT_W]);
    end

    // Priority select: the lowest matching index wins
    always_comb begin
        idx = '0;
        for (int i = NUM_DEV - 1; i >= 0; i--) begin
            if (match[i]) idx = IDX_W'(i);
        end
    end

    assign hit = |match;
endmodule

// File: rtl/cdr_ctrl.sv
// Command controller: accepts one command at a time and captures its fields.
// For a known unit it issues to the chosen device and waits for the result.
// For a null or unknown unit it applies the fallback mode at once.
// Assumes the selected device's ready and response signals are pre-muxed.
module cdr_ctrl
    import cdr_pkg::*;
#(
    parameter int        XLEN     = 32,
    parameter int        IDX_W    = 2,
    parameter fallback_e FALLBACK = FB_TRAP
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic [CMD_W-1:0]      req_cmd,
    input  logic [XLEN-1:0]       req_src1,
    input  logic [XLEN-1:0]       req_src2,
    input  logic                  lk_hit,
    input  logic [IDX_W-1:0]      lk_idx,
    input  logic                  sel_req_ready,
    input  logic                  sel_rsp_valid,
    input  logic [XLEN-1:0]       sel_rsp_data,
    output logic                  issue,
    output logic                  waiting,
    output logic [IDX_W-1:0]      sel_q,
    output logic [CMD_W-1:0]      cmd_q,
    output logic [XLEN-UNIT_W-1:0] data_q,
    output logic [XLEN-1:0]       src2_q,
    output logic [UNIT_W-1:0]     unit_q,
    output logic                  rsp_valid,
    output logic [XLEN-1:0]       rsp_data,
    output logic                  trap_valid,
    output logic [UNIT_W-1:0]     trap_unit
);
    ctl_state_e state;

    assign req_ready = (state == ST_IDLE);
    assign issue     = (state == ST_ISSUE);
    assign waiting   = (state == ST_WAIT);

    // Sequencing, field capture and result or trap generation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            sel_q      <= '0;
            cmd_q      <= '0;
            data_q     <= '0;
            src2_q     <= '0;
            unit_q     <= '0;
            rsp_valid  <= 1'b0;
            rsp_data   <= '0;
            trap_valid <= 1'b0;
            trap_unit  <= '0;
        end else begin
            rsp_valid  <= 1'b0;
            trap_valid <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        cmd_q  <= req_cmd;
                        data_q <= req_src1[XLEN-1:UNIT_W];
                        src2_q <= req_src2;
                        unit_q <= req_src1[UNIT_W-1:0];
                        if (lk_hit) begin
                            sel_q <= lk_idx;
                            state <= ST_ISSUE;
                        end else if (FALLBACK == FB_TRAP) begin
                            trap_valid <= 1'b1;
                            trap_unit  <= req_src1[UNIT_W-1:0];
                        end else begin
                            rsp_valid <= 1'b1;
                            rsp_data  <= (FALLBACK == FB_ONES) ? '1 : '0;
                        end
                    end
                end
                ST_ISSUE: if (sel_req_ready) state <= ST_WAIT;
                ST_WAIT: begin
                    if (sel_rsp_valid) begin
                        rsp_valid <= 1'b1;
                        rsp_data  <= sel_rsp_data;
                        state     <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R6: a trap strobe never comes with a write-back
    assert_trap_no_wb_R6: assert property (@(posedge clk) disable iff (!rst_n)
        trap_valid |-> !rsp_valid);
endmodule

// File: rtl/cmd_dispatch_router.sv
// Overloaded command dispatch router top level.
// Looks up the unit in req_src1[11:0] and hands the command to the controller.
// Fans the captured payload out to all devices, with valid/ready gated to the
// selected one, and muxes the selected device's result back.
// Assumes devices keep dev_rsp_valid low until their request is taken.
module cmd_dispatch_router
    import cdr_pkg::*;
#(
    parameter int XLEN    = 32,
    parameter int NUM_DEV = 4,
    parameter logic [NUM_DEV*UNIT_W-1:0] DEV_UNITS = {12'd4, 12'd3, 12'd2, 12'd1},
    parameter fallback_e FALLBACK = FB_TRAP
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req_valid,
    output logic                      req_ready,
    input  logic [2:0]                req_cmd,
    input  logic [XLEN-1:0]           req_src1,
    input  logic [XLEN-1:0]           req_src2,
    output logic                      rsp_valid,
    output logic [XLEN-1:0]           rsp_data,
    output logic                      trap_valid,
    output logic [11:0]               trap_unit,
    output logic [NUM_DEV-1:0]        dev_req_valid,
    input  logic [NUM_DEV-1:0]        dev_req_ready,
    output logic [2:0]                dev_req_cmd,
    output logic [XLEN-13:0]          dev_req_data,
    output logic [XLEN-1:0]           dev_req_src2,
    input  logic [NUM_DEV-1:0]        dev_rsp_valid,
    output logic [NUM_DEV-1:0]        dev_rsp_ready,
    input  logic [NUM_DEV*XLEN-1:0]   dev_rsp_data
);
    localparam int IDX_W = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1;

    logic             lk_hit;
    logic [IDX_W-1:0] lk_idx;
    logic             issue;
    logic             waiting;
    logic [IDX_W-1:0] sel_q;
    logic [UNIT_W-1:0] unit_q;
    logic             sel_req_ready;
    logic             sel_rsp_valid;
    logic [XLEN-1:0]  sel_rsp_data;

    cdr_unit_lookup #(
        .NUM_DEV (NUM_DEV),
        .UNIT_W  (UNIT_W),
        .IDX_W   (IDX_W),
        .UNIT_MAP(DEV_UNITS)
    ) u_lookup (
        .unit(req_src1[UNIT_W-1:0]),
        .hit (lk_hit),
        .idx (lk_idx)
    );

    cdr_ctrl #(
        .XLEN    (XLEN),
        .IDX_W   (IDX_W),
        .FALLBACK(FALLBACK)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_ready    (req_ready),
        .req_cmd      (req_cmd),
        .req_src1     (req_src1),
        .req_src2     (req_src2),
        .lk_hit       (lk_hit),
        .lk_idx       (lk_idx),
        .sel_req_ready(sel_req_ready),
        .sel_rsp_valid(sel_rsp_valid),
        .sel_rsp_data (sel_rsp_data),
        .issue        (issue),
        .waiting      (waiting),
        .sel_q        (sel_q),
        .cmd_q        (dev_req_cmd),
        .data_q       (dev_req_data),
        .src2_q       (dev_req_src2),
        .unit_q       (unit_q),
        .rsp_valid    (rsp_valid),
        .rsp_data     (rsp_data),
        .trap_valid   (trap_valid),
        .trap_unit    (trap_unit)
    );

    // Per-port gating of request valid and response ready
    for (genvar g = 0; g < NUM_DEV; g++) begin : g_port
        assign dev_req_valid[g] = issue   && (sel_q == IDX_W'(g));
        assign dev_rsp_ready[g] = waiting && (sel_q == IDX_W'(g));
    end

    // Return path: pick the selected device's handshake and result
    always_comb begin
        sel_req_ready = 1'b0;
        sel_rsp_valid = 1'b0;
        sel_rsp_data  = '0;
        for (int i = 0; i < NUM_DEV; i++) begin
            if (sel_q == IDX_W'(i)) begin
                sel_req_ready = dev_req_ready[i];
                sel_rsp_valid = dev_rsp_valid[i];
                sel_rsp_data  = dev_rsp_data[i*XLEN +: XLEN];
            end
        end
    end

    // R2: never more than one device addressed
    assert_onehot_dispatch_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dev_req_valid));

    // R6: a null unit is never forwarded to a device
    assert_no_null_dispatch_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (|dev_req_valid) |-> (unit_q != '0));

    // R5: the core is blocked while a device owns the command
    assert_busy_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((|dev_req_valid) || (|dev_rsp_ready)) |-> !req_ready);

    // R10: a stalled request holds valid and payload
    assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (|(dev_req_valid & ~dev_req_ready)) |=>
            ($stable(dev_req_valid) && $stable(dev_req_cmd) &&
             $stable(dev_req_data) && $stable(dev_req_src2)));
endmodule

// File: tb/sim_cmd_dispatch_router.sv
module sim_cmd_dispatch_router;
    import cdr_pkg::*;

    localparam int XLEN = 32;
    localparam int ND   = 4;
    localparam logic [ND*12-1:0] MAP = {12'hFFF, 12'h00A, 12'h002, 12'h001};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;   // 50 MHz

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // stimulus shared by all three instances
    logic            req_valid = 1'b0;
    logic            f1_valid = 1'b0;
    logic            f2_valid = 1'b0;
    logic [2:0]      b_cmd = '0;
    logic [XLEN-1:0] b_src1 = '0;
    logic [XLEN-1:0] b_src2 = '0;

    // u0 (trap mode) signals
    logic            req_ready, rsp_valid, trap_valid;
    logic [XLEN-1:0] rsp_data;
    logic [11:0]     trap_unit;
    logic [ND-1:0]   dev_req_valid, dev_req_ready, dev_rsp_valid, dev_rsp_ready;
    logic [2:0]      dev_req_cmd;
    logic [XLEN-13:0] dev_req_data;
    logic [XLEN-1:0] dev_req_src2;
    logic [ND*XLEN-1:0] dev_rsp_data;

    // fallback instances' signals
    logic            f1_ready, f1_rv, f1_tv, f2_ready, f2_rv, f2_tv;
    logic [XLEN-1:0] f1_rd, f2_rd;
    logic [11:0]     f1_tu, f2_tu;
    logic [ND-1:0]   f1_dv, f1_dr, f2_dv, f2_dr;
    logic [2:0]      f1_dc, f2_dc;
    logic [XLEN-13:0] f1_dd, f2_dd;
    logic [XLEN-1:0] f1_ds, f2_ds;

    cmd_dispatch_router #(.XLEN(XLEN), .NUM_DEV(ND), .DEV_UNITS(MAP), .FALLBACK(FB_TRAP)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_cmd(b_cmd), .req_src1(b_src1), .req_src2(b_src2),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .trap_valid(trap_valid), .trap_unit(trap_unit),
        .dev_req_valid(dev_req_valid), .dev_req_ready(dev_req_ready), .dev_req_cmd(dev_req_cmd),
        .dev_req_data(dev_req_data), .dev_req_src2(dev_req_src2), .dev_rsp_valid(dev_rsp_valid),
        .dev_rsp_ready(dev_rsp_ready), .dev_rsp_data(dev_rsp_data));

    cmd_dispatch_router #(.XLEN(XLEN), .NUM_DEV(ND), .DEV_UNITS(MAP), .FALLBACK(FB_ZERO)) u1 (
        .clk(clk), .rst_n(rst_n), .req_valid(f1_valid), .req_ready(f1_ready),
        .req_cmd(b_cmd), .req_src1(b_src1), .req_src2(b_src2),
        .rsp_valid(f1_rv), .rsp_data(f1_rd), .trap_valid(f1_tv), .trap_unit(f1_tu),
        .dev_req_valid(f1_dv), .dev_req_ready('0), .dev_req_cmd(f1_dc),
        .dev_req_data(f1_dd), .dev_req_src2(f1_ds), .dev_rsp_valid('0),
        .dev_rsp_ready(f1_dr), .dev_rsp_data('0));

    cmd_dispatch_router #(.XLEN(XLEN), .NUM_DEV(ND), .DEV_UNITS(MAP), .FALLBACK(FB_ONES)) u2 (
        .clk(clk), .rst_n(rst_n), .req_valid(f2_valid), .req_ready(f2_ready),
        .req_cmd(b_cmd), .req_src1(b_src1), .req_src2(b_src2),
        .rsp_valid(f2_rv), .rsp_data(f2_rd), .trap_valid(f2_tv), .trap_unit(f2_tu),
        .dev_req_valid(f2_dv), .dev_req_ready('0), .dev_req_cmd(f2_dc),
        .dev_req_data(f2_dd), .dev_req_src2(f2_ds), .dev_rsp_valid('0),
        .dev_rsp_ready(f2_dr), .dev_rsp_data('0));

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    // bench model of a device result
    function automatic logic [31:0] dev_fn(input int d, input logic [2:0] c,
                                           input logic [19:0] dt, input logic [31:0] s2);
        return {8'(d + 1), 1'b0, c, dt} ^ (s2 << 1);
    endfunction

    // expected items for the scoreboard: kind 0 = result, 1 = trap
    int              kind_q[$];
    logic [31:0]     val_q[$];
    int              exp_dev = -1;
    logic [2:0]      exp_cmd = '0;
    logic [19:0]     exp_data = '0;
    logic [31:0]     exp_src2 = '0;

    // device models: device i stalls i cycles on request and on response
    for (genvar gi = 0; gi < ND; gi++) begin : g_dev
        logic        rdy = 1'b0;
        logic        vld = 1'b0;
        logic [31:0] rdat = '0;
        assign dev_req_ready[gi] = rdy;
        assign dev_rsp_valid[gi] = vld;
        assign dev_rsp_data[gi*XLEN +: XLEN] = rdat;
        initial begin
            logic [2:0]  c0;
            logic [19:0] d0;
            logic [31:0] s0;
            forever begin
                @(negedge clk);
                if (rst_n && dev_req_valid[gi]) begin
                    chk(exp_dev == gi, "R2 device select", 32'(gi), 32'(exp_dev));
                    c0 = dev_req_cmd; d0 = dev_req_data; s0 = dev_req_src2;
                    chk(c0 == exp_cmd, "R3 cmd forwarded", 32'(c0), 32'(exp_cmd));
                    chk(d0 == exp_data, "R3 data forwarded", 32'(d0), 32'(exp_data));
                    chk(s0 == exp_src2, "R3 src2 forwarded", s0, exp_src2);
                    for (int k = 0; k < gi; k++) begin
                        @(negedge clk);
                        chk(dev_req_valid[gi] && dev_req_cmd == c0 && dev_req_data == d0 &&
                            dev_req_src2 == s0, "R10 request held", 32'(dev_req_data), 32'(d0));
                        chk(!req_ready, "R5 blocked while issuing", 32'(req_ready), 0);
                    end
                    rdy = 1'b1;
                    @(negedge clk);
                    rdy = 1'b0;
                    for (int k = 0; k < gi; k++) begin
                        @(negedge clk);
                        chk(!req_ready, "R5 blocked while waiting", 32'(req_ready), 0);
                    end
                    rdat = dev_fn(gi, c0, d0, s0);
                    vld = 1'b1;
                    @(negedge clk);
                    vld = 1'b0;
                end
            end
        end
    end

    // monitor: compare core-side results and traps with the scoreboard
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (|dev_req_valid)
                chk(!req_ready, "R5 ready low during issue", 32'(req_ready), 0);
            if (rsp_valid || trap_valid) begin
                chk(!(rsp_valid && trap_valid), "R6 trap without write-back", 32'(rsp_valid), 0);
                if (kind_q.size() == 0) begin
                    chk(1'b0, "R4 unexpected output", 32'(rsp_valid), 0);
                end else begin
                    int          k;
                    logic [31:0] v;
                    k = kind_q.pop_front();
                    v = val_q.pop_front();
                    if (k == 0) begin
                        chk(rsp_valid, "R4 result expected", 32'(trap_valid), 0);
                        chk(rsp_data == v, "R4 result value", rsp_data, v);
                    end else begin
                        chk(trap_valid, "R6/R9 trap expected", 32'(rsp_valid), 0);
                        chk(trap_unit == v[11:0], "R6/R9 trap unit", 32'(trap_unit), v);
                    end
                end
            end
        end
    end

    // driver: waits for ready, pushes the expected item, presents the command
    task automatic send(input logic [2:0] c, input logic [11:0] unit, input logic [19:0] up,
                        input logic [31:0] s2, input int dev);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        exp_dev = dev; exp_cmd = c; exp_data = up; exp_src2 = s2;
        if (dev < 0) begin
            kind_q.push_back(1); val_q.push_back(32'(unit));
        end else begin
            kind_q.push_back(0); val_q.push_back(dev_fn(dev, c, up, s2));
        end
        b_cmd = c; b_src1 = {up, unit}; b_src2 = s2;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // one command into a fallback-mode instance; checked one cycle later
    task automatic fb_test(input int which, input logic [11:0] unit, input logic [19:0] up,
                           input string tag);
        @(negedge clk);
        b_cmd = 3'd5; b_src1 = {up, unit}; b_src2 = 32'h1234_5678;
        if (which == 1) f1_valid = 1'b1; else f2_valid = 1'b1;
        @(negedge clk);
        f1_valid = 1'b0; f2_valid = 1'b0;
        if (which == 1) begin
            chk(f1_rv, {tag, " valid"}, 32'(f1_rv), 1);
            chk(f1_rd == 32'h0, {tag, " zero value"}, f1_rd, 32'h0);
            chk(!f1_tv && f1_dv == '0, {tag, " no trap/dispatch"}, 32'(f1_dv), 0);
        end else begin
            chk(f2_rv, {tag, " valid"}, 32'(f2_rv), 1);
            chk(f2_rd == 32'hFFFF_FFFF, {tag, " ones value"}, f2_rd, 32'hFFFF_FFFF);
            chk(!f2_tv && f2_dv == '0, {tag, " no trap/dispatch"}, 32'(f2_dv), 0);
        end
        @(negedge clk);
        chk(!f1_rv && !f2_rv, {tag, " single-cycle"}, 32'(f1_rv | f2_rv), 0);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: idle after reset
        chk(req_ready, "R1 ready after reset", 32'(req_ready), 1);
        chk(!rsp_valid && !trap_valid, "R1 no outputs after reset", 32'({rsp_valid, trap_valid}), 0);
        chk(dev_req_valid == '0, "R1 no device request", 32'(dev_req_valid), 0);

        // R2 R3 R4: every device, varied commands and data
        send(3'd0, 12'h001, 20'hABCDE, 32'hDEAD_BEEF, 0);
        send(3'd7, 12'h002, 20'h00001, 32'h0000_0001, 1);
        send(3'd3, 12'h00A, 20'hFFFFF, 32'h8000_0000, 2);
        send(3'd6, 12'hFFF, 20'h5A5A5, 32'hFFFF_FFFF, 3);   // top unit value
        // R6: unit 0 traps, R9: unmapped nonzero units trap
        send(3'd1, 12'h000, 20'h12345, 32'h0, -1);
        send(3'd2, 12'h003, 20'h0, 32'h1, -1);
        send(3'd4, 12'hFFE, 20'hFFFFF, 32'h2, -1);
        // back-to-back: hit after trap, trap after hit
        send(3'd5, 12'h00A, 20'h00F0F, 32'h1357_9BDF, 2);
        send(3'd0, 12'h000, 20'h0, 32'h0, -1);
        send(3'd2, 12'hFFF, 20'hC0FFE, 32'h0F0F_0F0F, 3);
        for (int c = 0; c < 8; c++) send(3'(c), 12'h002, 20'(c * 4099), 32'(c * 77), 1);

        // drain the scoreboard
        for (int t = 0; t < 200 && kind_q.size() != 0; t++) @(negedge clk);
        repeat (3) @(negedge clk);
        chk(kind_q.size() == 0, "R4 all results seen", 32'(kind_q.size()), 0);

        // R7 R8 R9 on the fallback instances
        fb_test(1, 12'h000, 20'hFFFFF, "R7 zero mode unit 0");
        fb_test(1, 12'h005, 20'h0, "R9 zero mode unmapped");
        fb_test(2, 12'h000, 20'h0, "R8 ones mode unit 0");
        fb_test(2, 12'h7FF, 20'h1, "R9 ones mode unmapped");
        finish_run();
    end
endmodule